// File: doc/BRIEF.md
# DRAM Bank Timing State Tracker

This block holds the timing state of every bank in one DRAM rank. For each bank it records whether a row is open and which one, together with three absolute cycle stamps: the cycle at which the bank is free for a new column command, the earliest cycle at which it may be precharged, and the earliest cycle at which it may be activated again. A memory controller uses it in two ways. It asks for an estimated access latency for a proposed request (bank and row) at the current cycle, and the answer is available combinationally in the same cycle. It also reports each access it has chosen to perform (a commit), and the tracker updates that bank's state on the next clock edge.

The timing constants (row-to-column delay, column latency, precharge time, minimum row-active time and write recovery time) are parameters in controller clock cycles. The current cycle count is supplied by the controller on `now_i`. Its own cycle-count register belongs to the controller, not to this block. The precharge bound combines the minimum row-active time after an activate with write recovery after the end of write data. The next-activate bound always trails that precharge bound by the precharge time.

Top module: `bank_timing_tracker`

## Requirements
- R1: After reset every bank has no open row and all three stamps are zero, so a query to any bank at cycle `now` reports a miss (`q_hit_o`=0) with latency T_RCD+T_CL.
- R2: A query whose row matches the bank's open row reports `q_hit_o`=1 and latency max(free,now)-now+T_CL.
- R3: A query to a bank with no open row reports a miss. Its activate cycle is the later of max(free,now) and the earliest-activate stamp, and its latency is that activate cycle minus `now` plus T_RCD+T_CL.
- R4: A query to a bank holding a different open row reports a miss. The close starts at the latest of free, earliest-precharge and `now`, and T_RP is added. The activate cycle is the later of that result and the earliest-activate stamp, and the latency is that activate cycle minus `now` plus T_RCD+T_CL.
- R5: A committed miss opens the committed row. The earliest-precharge stamp becomes the activate cycle plus T_RAS, and the free stamp becomes `now` plus the estimated latency.
- R6: A committed write (`c_write_i`=1) raises the earliest-precharge stamp to at least `c_data_end_i`+T_WR.
- R7: After every commit, the earliest-activate stamp becomes the maximum of its old value and the new earliest-precharge stamp plus T_RP.
- R8: A commit with `c_auto_pre_i`=1 leaves the bank with no open row, and its free stamp becomes max(free, earliest-precharge)+T_RP, both taken after the access update.
- R9: A commit takes effect at the next clock edge. A query and a commit to the same bank in one cycle see the pre-commit state, and a bank that receives no commit keeps its state unchanged.
- R10: A committed row hit keeps the row open, sets the free stamp to max(free,now)+T_CL, and leaves the earliest-precharge stamp unchanged for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| now_i | input | 32 | Current controller cycle count |
| q_bank_i | input | BANK_W | Bank of the proposed request |
| q_row_i | input | ROW_W | Row of the proposed request |
| q_hit_o | output | 1 | Proposed request hits the open row |
| q_lat_o | output | 32 | Estimated access latency in cycles |
| c_valid_i | input | 1 | Commit an access this cycle |
| c_bank_i | input | BANK_W | Bank of the committed access |
| c_row_i | input | ROW_W | Row of the committed access |
| c_write_i | input | 1 | Committed access is a write |
| c_auto_pre_i | input | 1 | Close the row after the committed access |
| c_data_end_i | input | 32 | Cycle at which the committed access's data transfer ends |

## Verification
The latency query and a commit can land on the same bank in the same cycle. The query must then report the state from before the commit, and the commit must be visible from the next cycle on. The bench provokes this with a directed case that commits and queries one bank and row together and then repeats the query. It also issues many random cycles in which the commit bank is often forced equal to the query bank. A behavioural model updated only after each rising edge predicts hit and latency, and these are compared in every cycle, including idle stretches where the pending waits run down.

// File: rtl/bt_pkg.sv
package bt_pkg;

    localparam int STAMP_W = 32;

    typedef logic [STAMP_W-1:0] stamp_t;

    // Per-bank absolute cycle stamps
    typedef struct packed {
        stamp_t free_at;   // bank accepts a new column command
        stamp_t pre_ok;    // earliest precharge
        stamp_t act_ok;    // earliest activate
    } bank_times_t;

    // Result of a latency estimate
    typedef struct packed {
        logic   hit;
        stamp_t lat;
        stamp_t act_at;    // activate cycle on a miss, zero on a hit
    } est_t;

    function automatic stamp_t smax(input stamp_t a, input stamp_t b);
        return (a > b) ? a : b;
    endfunction

    // Latency estimate for one bank at cycle 'now'
    function automatic est_t bt_estimate(
        input bank_times_t t,
        input logic        is_open,
        input logic        row_eq,
        input stamp_t      now,
        input stamp_t      rcd,
        input stamp_t      cl,
        input stamp_t      rp
    );
        est_t   e;
        stamp_t start;
        stamp_t pdly;
        e     = '0;
        start = t.free_at;
        pdly  = '0;
        if (is_open && row_eq) begin
            e.hit = 1'b1;
            start = smax(t.free_at, now);
            e.lat = start - now + cl;
        end else begin
            if (is_open) begin
                start = smax(t.pre_ok, t.free_at);
                pdly  = rp;
            end
            start    = smax(start, now) + pdly;
            e.act_at = smax(start, t.act_ok);
            e.lat    = e.act_at - now + rcd + cl;
        end
        return e;
    endfunction

endpackage

// File: rtl/bt_bank.sv
module bt_bank
    import bt_pkg::*;
#(
    parameter int ROW_W = 14,
    parameter int T_RCD = 5,
    parameter int T_CL  = 5,
    parameter int T_RP  = 5,
    parameter int T_RAS = 14,
    parameter int T_WR  = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  stamp_t           now,
    input  logic             commit,
    input  logic [ROW_W-1:0] c_row,
    input  logic             c_write,
    input  logic             c_auto_pre,
    input  stamp_t           c_data_end,
    output bank_times_t      times,
    output logic             row_open,
    output logic [ROW_W-1:0] open_row
);

    localparam stamp_t RCD_S = stamp_t'(T_RCD);
    localparam stamp_t CL_S  = stamp_t'(T_CL);
    localparam stamp_t RP_S  = stamp_t'(T_RP);
    localparam stamp_t RAS_S = stamp_t'(T_RAS);
    localparam stamp_t WR_S  = stamp_t'(T_WR);

    bank_times_t      st_q, st_d;
    logic             open_q, open_d;
    logic [ROW_W-1:0] row_q, row_d;
    est_t             c_est;

    always_comb begin
        c_est  = bt_estimate(st_q, open_q, row_q == c_row, now, RCD_S, CL_S, RP_S);
        st_d   = st_q;
        open_d = open_q;
        row_d  = row_q;
        // Column command ends the bank's busy window in both cases
        st_d.free_at = now + c_est.lat;
        if (!c_est.hit) begin
            st_d.pre_ok = c_est.act_at + RAS_S;
            open_d      = 1'b1;
            row_d       = c_row;
        end
        if (c_write) begin
            st_d.pre_ok = smax(st_d.pre_ok, c_data_end + WR_S);
        end
        st_d.act_ok = smax(st_q.act_ok, st_d.pre_ok + RP_S);
        if (c_auto_pre) begin
            open_d       = 1'b0;
            st_d.free_at = smax(st_d.free_at, st_d.pre_ok) + RP_S;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (commit) begin
            st_q   <= st_d;
            open_q <= open_d;
            row_q  <= row_d;
        end
    end

    assign times    = st_q;
    assign row_open = open_q;
    assign open_row = row_q;

    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (!open_q && st_q.free_at == '0 && st_q.pre_ok == '0 && st_q.act_ok == '0)); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(st_q) && $stable(open_q) && $stable(row_q))); // R9
    AST_NEW_ROW_OPEN: assert property (@(posedge clk) disable iff (rst)
        (commit && !c_auto_pre) |=> (open_q && row_q == $past(c_row))); // R5
    AST_WR_RECOVERY: assert property (@(posedge clk) disable iff (rst)
        (commit && c_write) |=> (st_q.pre_ok >= $past(c_data_end) + WR_S)); // R6
    AST_ACT_AFTER_PRE: assert property (@(posedge clk) disable iff (rst)
        commit |=> (st_q.act_ok >= st_q.pre_ok + RP_S)); // R7
    AST_AUTO_CLOSE: assert property (@(posedge clk) disable iff (rst)
        (commit && c_auto_pre) |=> (!open_q && st_q.free_at >= st_q.pre_ok + RP_S)); // R8

endmodule

// File: rtl/bt_query.sv
module bt_query
    import bt_pkg::*;
#(
    parameter int T_RCD = 5,
    parameter int T_CL  = 5,
    parameter int T_RP  = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  stamp_t      now,
    input  bank_times_t times,
    input  logic        row_open,
    input  logic        row_eq,
    output logic        hit,
    output stamp_t      lat
);

    localparam stamp_t RCD_S = stamp_t'(T_RCD);
    localparam stamp_t CL_S  = stamp_t'(T_CL);
    localparam stamp_t RP_S  = stamp_t'(T_RP);

    est_t q_est;
    logic unused_act;

    always_comb begin
        q_est = bt_estimate(times, row_open, row_eq, now, RCD_S, CL_S, RP_S);
    end

    assign hit        = q_est.hit;
    assign lat        = q_est.lat;
    assign unused_act = ^q_est.act_at;

    AST_HIT_NEEDS_OPEN: assert property (@(posedge clk) disable iff (rst)
        hit |-> (row_open && row_eq && lat >= CL_S)); // R2
    AST_MISS_FLOOR: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (lat >= RCD_S + CL_S)); // R3
    AST_CLOSE_COST: assert property (@(posedge clk) disable iff (rst)
        (row_open && !row_eq) |-> (lat >= RP_S + RCD_S + CL_S)); // R4

endmodule

// File: rtl/bank_timing_tracker.sv
module bank_timing_tracker
    import bt_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    parameter int T_RCD     = 5,
    parameter int T_CL      = 5,
    parameter int T_RP      = 5,
    parameter int T_RAS     = 14,
    parameter int T_WR      = 6,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       now_i,
    input  logic [BANK_W-1:0] q_bank_i,
    input  logic [ROW_W-1:0]  q_row_i,
    output logic              q_hit_o,
    output logic [31:0]       q_lat_o,
    input  logic              c_valid_i,
    input  logic [BANK_W-1:0] c_bank_i,
    input  logic [ROW_W-1:0]  c_row_i,
    input  logic              c_write_i,
    input  logic              c_auto_pre_i,
    input  logic [31:0]       c_data_end_i
);

    bank_times_t      bank_times [NUM_BANKS];
    logic             bank_open  [NUM_BANKS];
    logic [ROW_W-1:0] bank_row   [NUM_BANKS];

    for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
        bt_bank #(
            .ROW_W (ROW_W),
            .T_RCD (T_RCD),
            .T_CL  (T_CL),
            .T_RP  (T_RP),
            .T_RAS (T_RAS),
            .T_WR  (T_WR)
        ) u_bank (
            .clk        (clk),
            .rst        (rst),
            .now        (now_i),
            .commit     (c_valid_i && (c_bank_i == BANK_W'(gb))),
            .c_row      (c_row_i),
            .c_write    (c_write_i),
            .c_auto_pre (c_auto_pre_i),
            .c_data_end (c_data_end_i),
            .times      (bank_times[gb]),
            .row_open   (bank_open[gb]),
            .open_row   (bank_row[gb])
        );
    end

    bt_query #(
        .T_RCD (T_RCD),
        .T_CL  (T_CL),
        .T_RP  (T_RP)
    ) u_query (
        .clk      (clk),
        .rst      (rst),
        .now      (now_i),
        .times    (bank_times[q_bank_i]),
        .row_open (bank_open[q_bank_i]),
        .row_eq   (bank_row[q_bank_i] == q_row_i),
        .hit      (q_hit_o),
        .lat      (q_lat_o)
    );

endmodule

// File: tb/tb_bank_timing_tracker.sv
module tb_bank_timing_tracker;

    localparam int NB  = 8;
    localparam int RW  = 14;
    localparam int BW  = 3;
    localparam int RCD = 5;
    localparam int CL  = 5;
    localparam int RP  = 5;
    localparam int RAS = 14;
    localparam int WR  = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [31:0]   now_c = '0;
    logic [BW-1:0] q_bank = '0;
    logic [RW-1:0] q_row = '0;
    logic          q_hit;
    logic [31:0]   q_lat;
    logic          c_valid = 1'b0;
    logic [BW-1:0] c_bank = '0;
    logic [RW-1:0] c_row = '0;
    logic          c_write = 1'b0;
    logic          c_auto = 1'b0;
    logic [31:0]   c_dend = '0;

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) now_c <= rst ? 32'd0 : now_c + 32'd1;

    bank_timing_tracker #(
        .NUM_BANKS (NB), .ROW_W (RW), .T_RCD (RCD), .T_CL (CL),
        .T_RP (RP), .T_RAS (RAS), .T_WR (WR)
    ) dut (
        .clk (clk), .rst (rst), .now_i (now_c),
        .q_bank_i (q_bank), .q_row_i (q_row), .q_hit_o (q_hit), .q_lat_o (q_lat),
        .c_valid_i (c_valid), .c_bank_i (c_bank), .c_row_i (c_row),
        .c_write_i (c_write), .c_auto_pre_i (c_auto), .c_data_end_i (c_dend)
    );

    // Behavioural reference state
    longint m_free [NB];
    longint m_pre  [NB];
    longint m_act  [NB];
    bit     m_open [NB];
    int     m_row  [NB];

    int checks = 0;
    int fails  = 0;

    function automatic longint lmax(longint a, longint b);
        return (a > b) ? a : b;
    endfunction

    task automatic model_est(input int b, input int row, input longint now,
                             output bit hit, output longint lat, output longint act);
        longint t;
        if (m_open[b] && m_row[b] == row) begin
            hit = 1'b1;
            lat = lmax(m_free[b], now) - now + CL;
            act = 0;
        end else begin
            hit = 1'b0;
            if (m_open[b]) t = lmax(lmax(m_free[b], m_pre[b]), now) + RP;
            else           t = lmax(m_free[b], now);
            act = lmax(t, m_act[b]);
            lat = act - now + RCD + CL;
        end
    endtask

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, now_c);
        end
    endtask

    // One cycle: drive query and optional commit, compare, then advance the model
    task automatic step(input string tag, input int qb, input int qr, input bit cv,
                        input int cb, input int cr, input bit cw, input bit ca);
        bit     qh, ch;
        longint ql, qa, cl_, ca_, now, dend;
        @(negedge clk);
        now = longint'(now_c);
        model_est(cb, cr, now, ch, cl_, ca_);
        dend    = now + cl_ + 4;
        q_bank  = BW'(qb);
        q_row   = RW'(qr);
        c_valid = cv;
        c_bank  = BW'(cb);
        c_row   = RW'(cr);
        c_write = cw;
        c_auto  = ca;
        c_dend  = 32'(dend);
        #1;
        model_est(qb, qr, now, qh, ql, qa);
        check(tag, "hit", longint'(q_hit), longint'(qh));
        check(tag, "latency", longint'(q_lat), ql);
        @(posedge clk);
        if (cv) begin
            m_free[cb] = now + cl_;
            if (!ch) begin
                m_pre[cb]  = ca_ + RAS;
                m_open[cb] = 1'b1;
                m_row[cb]  = cr;
            end
            if (cw) m_pre[cb] = lmax(m_pre[cb], dend + WR);
            m_act[cb] = lmax(m_act[cb], m_pre[cb] + RP);
            if (ca) begin
                m_open[cb] = 1'b0;
                m_free[cb] = lmax(m_free[cb], m_pre[cb]) + RP;
            end
        end
    endtask

    task automatic idle(input string tag, input int qb, input int qr, input int n);
        for (int i = 0; i < n; i++) step(tag, qb, qr, 1'b0, 0, 0, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            m_free[b] = 0; m_pre[b] = 0; m_act[b] = 0; m_open[b] = 0; m_row[b] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state seen through queries on every bank
        for (int b = 0; b < NB; b++) step("R1", b, 0, 1'b0, 0, 0, 1'b0, 1'b0);

        // R3: open row 5 in bank 0 from the empty state
        step("R3", 0, 5, 1'b1, 0, 5, 1'b0, 1'b0);
        // R2: hits while the column latency runs down
        idle("R2", 0, 5, 3);
        // R10: hit commits back to back
        step("R10", 0, 5, 1'b1, 0, 5, 1'b0, 1'b0);
        step("R10", 0, 5, 1'b1, 0, 5, 1'b0, 1'b0);
        idle("R10", 0, 5, 2);
        // R4: conflicting row while tRAS holds the precharge back
        idle("R4", 0, 7, 18);
        // R5: open the conflicting row, then hit and miss it
        step("R5", 0, 7, 1'b1, 0, 7, 1'b0, 1'b0);
        idle("R5", 0, 7, 3);
        idle("R5", 0, 8, 3);
        // R6: write opens bank 1, write recovery bounds the precharge
        step("R6", 1, 3, 1'b1, 1, 3, 1'b1, 1'b0);
        idle("R6", 1, 4, 25);
        step("R6", 1, 3, 1'b1, 1, 3, 1'b1, 1'b0);
        idle("R6", 1, 4, 6);
        // R7: read miss after the write, activate bound follows precharge
        step("R7", 1, 4, 1'b1, 1, 4, 1'b0, 1'b0);
        idle("R7", 1, 9, 8);
        // R8: auto-precharge closes bank 2, no precharge delay on next miss
        step("R8", 2, 1, 1'b1, 2, 1, 1'b0, 1'b1);
        idle("R8", 2, 1, 25);
        step("R8", 2, 6, 1'b1, 2, 6, 1'b1, 1'b1);
        idle("R8", 2, 6, 30);
        // R9: same-cycle query and commit on one bank see the old state
        step("R9", 3, 9, 1'b1, 3, 9, 1'b0, 1'b0);
        step("R9", 3, 9, 1'b0, 0, 0, 1'b0, 1'b0);
        step("R9", 4, 2, 1'b1, 3, 2, 1'b0, 1'b0);
        idle("R9", 4, 2, 2);

        // R9: random mix, commit bank often equal to query bank
        for (int i = 0; i < 600; i++) begin
            int qb, qr, cb, cr;
            bit cv, cw, ca;
            qb = int'($urandom_range(0, NB - 1));
            qr = int'($urandom_range(0, 2));
            cv = ($urandom_range(0, 2) == 0);
            cb = ($urandom_range(0, 1) == 0) ? qb : int'($urandom_range(0, NB - 1));
            cr = int'($urandom_range(0, 2));
            cw = ($urandom_range(0, 1) == 0);
            ca = ($urandom_range(0, 5) == 0);
            step("R9", qb, qr, cv, cb, cr, cw, ca);
        end
        for (int b = 0; b < NB; b++) idle("R9", b, 1, 4);

        finish_run();
    end

endmodule